// File: doc/BRIEF.md
# Tri-state phase-frequency comparator

This block compares a reference clock A with a feedback clock B. Both are slow, clock-like signals that it samples in its own system clock domain. The result is a charge-pump command on two wires: `drv_en` says whether the command is driven, and `drv_val` gives the driven level. When `drv_en` is low the command is released, and the external loop filter holds its charge.

In edge mode only rising edges matter. Whichever input rises first sets the direction of the command, and a rising edge on the other input releases it. Because the tracker remembers a pending edge, two rising edges on one input with none on the other read as a frequency error. That error lasts until the other input rises. To stop bounced edges from being counted this way, each input passes through a two-flop synchronizer and a deglitch filter of programmable length. An exclusive-OR mode is the fallback: there the command is always driven and equals A XOR B, so extra transitions do no lasting harm.

Two saturating counters record how many cycles the command spends driven high and driven low. A mode change waits until the edge tracker has no pending edge, so the switch itself never produces a spurious driven pulse.

Top module: `pfd_tristate`

## Requirements
- R1: After reset `drv_en` is 0 and both cycle counters read 0.
- R2: In edge mode, when A rises with no pending edge, the command is driven high (`drv_en`=1, `drv_val`=1) until B next rises, and is then released.
- R3: In edge mode, when B rises with no pending edge, the command is driven low (`drv_en`=1, `drv_val`=0) until A next rises, and is then released.
- R4: Two rising edges of B with no rising edge of A between them leave the command driven low until A next rises.
- R5: Rising edges of A and B that reach the comparator in the same system cycle cancel: the command is released, or stays released.
- R6: In edge mode, falling edges and duty cycle have no effect on the command.
- R7: When A is faster than B, the command is driven high for most cycles. When A is slower than B, it is driven low for most cycles.
- R8: In exclusive-OR mode (`xor_mode`=1) `drv_en` is 1 and `drv_val` equals A XOR B.
- R9: A new value on `xor_mode` is taken up only while the edge tracker has no pending edge. While an edge is pending, the previous mode stays in force.
- R10: With `filt_len`=N>0, a level change on an input that lasts fewer than N system cycles after synchronization is ignored. A change that lasts longer is accepted.
- R11: `up_cnt` counts the cycles with the command driven high and `dn_cnt` counts the cycles driven low. Each saturates at all ones. `cnt_clr` sets both to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| ref_in | input | 1 | reference input A (asynchronous) |
| fb_in | input | 1 | feedback input B (asynchronous) |
| xor_mode | input | 1 | 1 selects exclusive-OR comparison, 0 selects edge mode |
| filt_len | input | FILT_W | deglitch stability length in system cycles, 0 bypasses the filter |
| cnt_clr | input | 1 | clears both cycle counters |
| drv_en | output | 1 | 1 when the command is driven, 0 when released |
| drv_val | output | 1 | driven level of the command |
| up_cnt | output | CNT_W | cycles driven high, saturating |
| dn_cnt | output | CNT_W | cycles driven low, saturating |

## Verification
A rising edge on A and a rising edge on B can reach the edge tracker in the same system cycle. That cycle calls for both a high drive and a low drive, and the block must cancel them. The bench provokes this by raising both inputs together, so the two edges leave the synchronizers and filters in the same cycle. It then judges the outcome by sampling `drv_en` on every cycle for a window long enough to cover the pipeline, and counts any driven cycle as a failure. The same collision is used from a driven-high state, where it must return the command to released.

// File: rtl/pfd_tristate.sv
module pfd_tristate #(
  parameter int FILT_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic              fb_in,
  input  logic              xor_mode,
  input  logic [FILT_W-1:0] filt_len,
  input  logic              cnt_clr,
  output logic              drv_en,
  output logic              drv_val,
  output logic [CNT_W-1:0]  up_cnt,
  output logic [CNT_W-1:0]  dn_cnt
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  typedef enum logic [1:0] {ST_REL, ST_UP, ST_DN} st_t;

  logic [1:0] raw, s1, s2, flt, prv, rise;
  logic [FILT_W-1:0] fcnt [2];
  st_t  st, st_n;
  logic mode_q;

  assign raw = {fb_in, ref_in};

  for (genvar g = 0; g < 2; g++) begin : g_in
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[g]   <= 1'b0;
        s2[g]   <= 1'b0;
        flt[g]  <= 1'b0;
        prv[g]  <= 1'b0;
        fcnt[g] <= '0;
      end else begin
        s1[g]  <= raw[g];
        s2[g]  <= s1[g];
        prv[g] <= flt[g];
        if (filt_len == '0) begin
          flt[g]  <= s2[g];
          fcnt[g] <= '0;
        end else if (s2[g] == flt[g]) begin
          fcnt[g] <= '0;
        end else if (fcnt[g] == filt_len - 1'b1) begin
          flt[g]  <= s2[g];
          fcnt[g] <= '0;
        end else begin
          fcnt[g] <= fcnt[g] + 1'b1;
        end
      end
    end
    assign rise[g] = flt[g] & ~prv[g];
  end

  always_comb begin
    st_n = st;
    if (rise[0] && rise[1]) st_n = ST_REL;
    else if (rise[0])       st_n = (st == ST_DN) ? ST_REL : ST_UP;
    else if (rise[1])       st_n = (st == ST_UP) ? ST_REL : ST_DN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_REL;
      mode_q <= 1'b0;
    end else begin
      st <= st_n;
      if (st == ST_REL) mode_q <= xor_mode;
    end
  end

  assign drv_en  = mode_q | (st != ST_REL);
  assign drv_val = mode_q ? (flt[0] ^ flt[1]) : (st == ST_UP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_cnt <= '0;
      dn_cnt <= '0;
    end else if (cnt_clr) begin
      up_cnt <= '0;
      dn_cnt <= '0;
    end else begin
      if (drv_en && drv_val && up_cnt != CMAX)  up_cnt <= up_cnt + 1'b1;
      if (drv_en && !drv_val && dn_cnt != CMAX) dn_cnt <= dn_cnt + 1'b1;
    end
  end

  // R5
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && rise[0] && rise[1]) |=> !drv_en);
  // R2
  up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && drv_en && drv_val && !rise[1]) |=> (drv_en && drv_val));
  // R3
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && drv_en && !drv_val && !rise[0]) |=> (drv_en && !drv_val));
  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_REL) |=> $stable(mode_q));
  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == CMAX && !cnt_clr) |=> up_cnt == CMAX);
  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (up_cnt == '0 && dn_cnt == '0));
  // R8
  xor_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && $stable(mode_q)) |-> drv_en);

endmodule

// File: tb/pfd_tristate_test.sv
module pfd_tristate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 1'b0, b = 1'b0, xm = 1'b0, clr = 1'b0;
  logic [7:0] flen = 8'd0;
  logic en, val;
  logic [15:0] upc, dnc;
  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  pfd_tristate uut (
    .clk(clk), .rst_n(rst_n), .ref_in(a), .fb_in(b), .xor_mode(xm),
    .filt_len(flen), .cnt_clr(clr), .drv_en(en), .drv_val(val),
    .up_cnt(upc), .dn_cnt(dnc)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_idle();
    a = 0; b = 0; tick(8);
    a = 1; b = 1; tick(8);
    a = 0; b = 0; tick(8);
  endtask

  task automatic t_reset();
    chk(en == 0, "R1 drv_en", en, 0);
    chk(upc == 0 && dnc == 0, "R1 counters", upc + dnc, 0);
  endtask

  task automatic t_a_first();
    go_idle();
    a = 1; tick(6);
    chk(en && val, "R2 driven high", {en, val}, 3);
    a = 0; tick(6);
    chk(en && val, "R6 A fall ignored", {en, val}, 3);
    b = 1; tick(6);
    chk(!en, "R2 released on B rise", en, 0);
    b = 0; tick(6);
    chk(!en, "R6 B fall ignored", en, 0);
  endtask

  task automatic t_b_first();
    go_idle();
    b = 1; tick(6);
    chk(en && !val, "R3 driven low", {en, val}, 2);
    a = 1; tick(6);
    chk(!en, "R3 released on A rise", en, 0);
  endtask

  task automatic t_double_b();
    go_idle();
    b = 1; tick(6); b = 0; tick(6);
    b = 1; tick(6); b = 0; tick(6);
    chk(en && !val, "R4 low after two B edges", {en, val}, 2);
    a = 1; tick(6);
    chk(!en, "R4 released by A", en, 0);
  endtask

  task automatic t_cancel();
    int drv = 0;
    go_idle();
    a = 1; b = 1;
    for (int i = 0; i < 10; i++) begin tick(1); if (en) drv++; end
    chk(drv == 0, "R5 cancel from released", drv, 0);
    a = 0; b = 0; tick(6);
    a = 1; tick(6); a = 0; tick(6);
    a = 1; b = 1; tick(8);
    chk(!en, "R5 cancel from driven high", en, 0);
  endtask

  task automatic t_freq();
    go_idle();
    clr = 1; tick(1); clr = 0;
    for (int i = 0; i < 600; i++) begin a = (i % 20) < 10; b = (i % 30) < 15; tick(1); end
    chk(upc > 3 * dnc, "R7 A faster mostly high", upc, dnc);
    go_idle();
    clr = 1; tick(1); clr = 0;
    for (int i = 0; i < 600; i++) begin a = (i % 30) < 15; b = (i % 20) < 10; tick(1); end
    chk(dnc > 3 * upc, "R7 A slower mostly low", dnc, upc);
  endtask

  task automatic t_xor();
    go_idle();
    xm = 1; tick(4);
    for (int k = 0; k < 4; k++) begin
      a = k[0]; b = k[1]; tick(6);
      chk(en && val == (a ^ b), "R8 xor output", {en, val}, {1'b1, a ^ b});
    end
  endtask

  task automatic t_mode();
    a = 0; b = 0; tick(6);
    go_idle();
    xm = 1; tick(4);
    a = 1; tick(6);
    xm = 0; a = 0; tick(6);
    chk(en && !val, "R9 xor kept while pending", {en, val}, 2);
    b = 1; tick(6);
    chk(!en, "R9 edge mode after release", en, 0);
    go_idle();
    a = 1; tick(6);
    xm = 1; a = 0; tick(6);
    chk(en && val, "R9 edge kept while pending", {en, val}, 3);
    xm = 0; go_idle();
  endtask

  task automatic t_filter();
    go_idle();
    flen = 8'd4;
    b = 1; tick(2); b = 0; tick(10);
    chk(!en, "R10 short pulse ignored", en, 0);
    b = 1; tick(12);
    chk(en && !val, "R10 long level accepted", {en, val}, 2);
    a = 1; tick(12); a = 0; b = 0; tick(12);
    flen = 8'd0;
  endtask

  task automatic t_sat();
    go_idle();
    clr = 1; tick(1); clr = 0;
    a = 1; tick(66000);
    chk(upc == 16'hFFFF, "R11 up_cnt saturates", upc, 16'hFFFF);
    chk(dnc == 0, "R11 dn_cnt idle", dnc, 0);
    clr = 1; tick(1); clr = 0;
    chk(upc == 0 && dnc == 0, "R11 clear", upc, 0);
    go_idle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1; tick(2);
    t_reset();
    t_a_first();
    t_b_first();
    t_double_b();
    t_cancel();
    t_freq();
    t_xor();
    t_mode();
    t_filter();
    t_sat();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule